// File: doc/BRIEF.md
# SIMD Strided Reduction Array

This block adds up eight signed words with a row of processing elements (PEs) that all follow one shared step sequence. A start strobe loads every PE from a flat input vector in a single cycle. In each of the following three cycles, a chosen set of PEs adds in the value held by a partner PE a fixed stride further along the row. After the last step, element 0 holds the total. Busy marks the three step cycles. Done then pulses for one cycle.

A mode bit, captured with the start strobe, picks the order of the strides. Ascending order first pairs neighbours and then doubles the stride on each step. Descending order begins at half the row and halves the stride on each step. The sum output shows element 0 at all times, so the partial result of each step can be seen at the port. Additions wrap at the data width.

Top module: `simd_reduce_array`

## Requirements
- R1: While reset is held and just after it, busy and done are 0 and sum is 0.
- R2: A start seen while busy is low loads element i from load_data bits [i*W +: W] and latches the mode. Busy is 1 from the next cycle for exactly three cycles. A start in the cycle where done is high is accepted.
- R3: With mode 0 (ascending), step 1 adds element i+1 into element i for i = 0, 2, 4, 6. Step 2 adds element i+2 into element i for i = 0, 4. Step 3 adds element 4 into element 0. Sum therefore reads e0+e1 after step 1 and e0+e1+e2+e3 after step 2.
- R4: With mode 1 (descending), step 1 adds element i+4 into element i for i = 0..3. Step 2 adds element i+2 into element i for i = 0, 1. Step 3 adds element 1 into element 0. Sum therefore reads e0+e4 after step 1 and e0+e4+e2+e6 after step 2.
- R5: After the third step, sum equals the sum of all eight loaded words, in both modes.
- R6: Done is high for exactly one cycle, in the first cycle after busy falls. The total stays on sum until the next accepted start.
- R7: Additions wrap in two's complement at W bits, without saturation.
- R8: A start asserted while busy is high is ignored. The data and mode presented with it have no effect.
- R9: The mode input is sampled only on an accepted start. Changing it during an operation has no effect.
- R10: In each step, every PE that is not selected keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe; loads operands when idle |
| mode | input | 1 | Stride order: 0 ascending, 1 descending |
| load_data | input | N*W | Eight operands, element i at bits [i*W +: W] |
| busy | output | 1 | High during the three add steps |
| done | output | 1 | One-cycle pulse when the total is ready |
| sum | output | W | Current value of element 0; the total after done |

## Verification
The bench builds the array with its defaults: eight elements of 16 bits. With these values, an all-large operand set wraps past the signed range within a single reduction. Both stride orders and their distinct partial sums can also be seen on sum. Because each operand is a distinct power of two, every partial result identifies exactly which elements were combined, so a wrong mask or stride appears at once. Starts and mode changes during busy, and a start in the done cycle, cover the acceptance rules.

// File: rtl/simd_red_pkg.sv
package simd_red_pkg;

  // Partner distance for a given step (0-based) and stride order.
  function automatic int unsigned stride_of(input logic desc, input int unsigned step,
                                            input int unsigned n);
    if (desc) return n >> (step + 1);
    else      return 32'd1 << step;
  endfunction

  // Whether element idx adds in its partner during this step.
  function automatic logic is_active(input logic desc, input int unsigned step,
                                     input int unsigned idx, input int unsigned n);
    int unsigned s;
    s = stride_of(desc, step, n);
    if (desc) return idx < s;
    else      return (idx % (2 * s)) == 0;
  endfunction

endpackage

// File: rtl/red_seq.sv
module red_seq #(
  parameter int STEPS  = 3,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              load,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] step,
  output logic              mode_q
);
  logic last_step;

  assign load      = start & ~busy;
  assign last_step = busy && (int'(step) == STEPS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      mode_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        step   <= '0;
        mode_q <= mode;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode_q)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !last_step) |=> (busy && step == $past(step) + 1'b1)); // R8
  AST_BUSY_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (step == '0)); // R2

endmodule

// File: rtl/red_mask.sv
module red_mask
  import simd_red_pkg::*;
#(
  parameter int N      = 8,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              mode_q,
  input  logic [STEP_W-1:0] step,
  output logic [N-1:0]      act,
  output logic [31:0]       stride
);
  assign stride = stride_of(mode_q, int'(step), N);

  for (genvar i = 0; i < N; i++) begin : g_act
    assign act[i] = busy & is_active(mode_q, int'(step), i, N);
  end

  AST_ACT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(act) == (N >> (int'(step) + 1)))); // R3
  AST_ELEM0_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> act[0]); // R5

endmodule

// File: rtl/red_pe.sv
module red_pe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         act,
  input  logic [W-1:0] partner,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a, input logic [W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ld)  q <= ld_val;
    else if (act) q <= add_wrap(q, partner);
  end

  AST_PE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !act) |=> $stable(q)); // R10

endmodule

// File: rtl/simd_reduce_array.sv
module simd_reduce_array #(
  parameter int N = 8,
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           mode,
  input  logic [N*W-1:0] load_data,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   sum
);
  localparam int STEPS  = $clog2(N);
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic              load;
  logic              mode_q;
  logic [STEP_W-1:0] step;
  logic [N-1:0]      act;
  logic [31:0]       stride;
  logic [W-1:0]      pe_q    [N];
  logic [W-1:0]      partner [N];

  red_seq #(.STEPS(STEPS), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .load(load), .busy(busy), .done(done), .step(step), .mode_q(mode_q)
  );

  red_mask #(.N(N), .STEP_W(STEP_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mode_q(mode_q), .step(step),
    .act(act), .stride(stride)
  );

  for (genvar i = 0; i < N; i++) begin : g_pe
    always_comb begin
      partner[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (j == i + int'(stride)) partner[i] = pe_q[j];
      end
    end

    red_pe #(.W(W)) u_pe (
      .clk(clk), .rst_n(rst_n), .ld(load), .ld_val(load_data[i*W +: W]),
      .act(act[i]), .partner(partner[i]), .q(pe_q[i])
    );
  end

  assign sum = pe_q[0];

  AST_SUM_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sum)); // R6
  AST_LOAD_ELEM0: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sum == $past(load_data[W-1:0]))); // R2

endmodule

// File: tb/simd_reduce_array_bench.sv
module simd_reduce_array_bench;
  localparam int N = 8;
  localparam int W = 16;
  localparam int STEPS = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           mode = 1'b0;
  logic [N*W-1:0] load_data = '0;
  logic           busy, done;
  logic [W-1:0]   sum;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic cmp_en = 1'b0;

  always #2 clk = ~clk;

  simd_reduce_array #(.N(N), .W(W)) u_simd_reduce_array (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .load_data(load_data), .busy(busy), .done(done), .sum(sum)
  );

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d expected=%0d", req, got, exp);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge.
  logic [W-1:0] mdl [N];
  bit m_busy = 0, m_done = 0, m_mode = 0;
  int m_step = 0;

  always @(posedge clk) begin
    logic [W-1:0] nxt [N];
    int span;
    if (!rst_n) begin
      foreach (mdl[k]) mdl[k] = '0;
      m_busy = 0; m_done = 0; m_step = 0; m_mode = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        nxt = mdl;
        for (int i = 0; i < N; i++) begin
          if (m_mode) begin
            span = N / (2 ** (m_step + 1));
            if (i < span) nxt[i] = mdl[i] + mdl[i + span];
          end else begin
            span = 2 ** m_step;
            if (i % (2 * span) == 0) nxt[i] = mdl[i] + mdl[i + span];
          end
        end
        mdl = nxt;
        if (m_step == STEPS - 1) begin m_busy = 0; m_done = 1; end
        else m_step++;
      end else if (start) begin
        for (int i = 0; i < N; i++) mdl[i] = load_data[i*W +: W];
        m_mode = mode; m_busy = 1; m_step = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      check("R2 busy vs model", busy, m_busy);
      check("R6 done vs model", done, m_done);
      check("R5 sum vs model", sum, mdl[0]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog got=%0d expected=%0d", cyc, 20000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [W-1:0] el(input logic [N*W-1:0] v, input int i);
    return v[i*W +: W];
  endfunction

  // One full operation with directed checks on partial sums.
  task automatic do_op(input logic [N*W-1:0] v, input logic md, input bit disturb,
                       input logic [N*W-1:0] nxt_v, input bit chain);
    logic [W-1:0] p1, p2, tot;
    tot = '0;
    for (int i = 0; i < N; i++) tot = tot + el(v, i);
    if (md) begin
      p1 = el(v, 0) + el(v, 4);
      p2 = p1 + el(v, 2) + el(v, 6);
    end else begin
      p1 = el(v, 0) + el(v, 1);
      p2 = p1 + el(v, 2) + el(v, 3);
    end
    @(negedge clk); start = 1'b1; mode = md; load_data = v;
    @(negedge clk); start = 1'b0;
    check("R2 busy after start", busy, 1);
    check("R2 element 0 loaded", sum, el(v, 0));
    if (disturb) begin
      start = 1'b1; mode = ~md; load_data = ~v; // R8 R9 stimulus
    end
    @(negedge clk); start = 1'b0; if (disturb) mode = ~md;
    check(md ? "R4 step1 partial" : "R3 step1 partial", sum, p1);
    @(negedge clk);
    check(md ? "R4 step2 partial" : "R3 step2 partial", sum, p2);
    check("R2 busy in step 3", busy, 1);
    @(negedge clk);
    check("R6 busy low at done", busy, 0);
    check("R6 done high", done, 1);
    check(disturb ? "R8 total unaffected" : "R5 total", sum, tot);
    if (chain) begin
      start = 1'b1; mode = ~md; load_data = nxt_v;
      @(negedge clk); start = 1'b0;
      check("R2 start in done cycle accepted", busy, 1);
      check("R2 chained load", sum, el(nxt_v, 0));
      repeat (4) @(negedge clk);
    end else begin
      @(negedge clk);
      check("R6 done one cycle", done, 0);
      check("R6 total held", sum, tot);
    end
  endtask

  initial begin
    logic [N*W-1:0] pw, big, neg;
    for (int i = 0; i < N; i++) begin
      pw[i*W +: W]  = W'(1 << i);
      big[i*W +: W] = 16'h7000;
      neg[i*W +: W] = W'(-(i * 37 + 5));
    end
    repeat (3) @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 done in reset", done, 0);
    check("R1 sum in reset", sum, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", busy, 0);
    check("R1 sum after reset", sum, 0);
    cmp_en = 1'b1;
    do_op(pw, 1'b0, 0, '0, 0);        // R3 R5 R10
    do_op(pw, 1'b1, 0, '0, 0);        // R4 R5 R10
    do_op(big, 1'b0, 0, '0, 0);       // R7 wrap: 8*0x7000 -> 0x8000
    check("R7 wrapped total", sum, 16'h8000);
    do_op(neg, 1'b1, 0, '0, 0);       // R5 with negatives
    do_op(pw, 1'b0, 1, '0, 0);        // R8 R9 start/mode during busy
    do_op(pw, 1'b1, 1, '0, 0);        // R8 R9 descending
    do_op(neg, 1'b0, 0, pw, 1);       // R2 chained start in done cycle
    repeat (2) @(negedge clk);
    cmp_en = 1'b0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule